// File: doc/BRIEF.md
# Add/Subtract/Compare Unit with Condition Flags and Decimal/Nibble Modes

This block is the arithmetic core of a small 8/16-bit processor datapath. It adds, subtracts or compares two operands and reports four condition flags. These are zero, carry, overflow and negative. Each operation is presented for one cycle with `in_valid`. One clock later the result, a write-back strobe and the flags appear, qualified by `out_valid`.

Two mode inputs change how narrow (8-bit) operations behave:

- **Decimal mode** treats the operands as packed BCD digits. Only zero and carry can then be reported.
- **Unpack mode** narrows the work to the low nibble and clears everything above it.

When both modes are set, a single BCD digit is processed. A 16-bit operation is always plain binary and ignores both mode inputs. Compares update the flags but never request a register write.

Top module: `alu_flag_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock, and `result`, `flags` and `out_valid` are zero during reset (`rst_n` low).
- R2: The flag bits are Z=`flags[0]`, C=`flags[1]`, V=`flags[2]` and N=`flags[3]`. Z is 1 exactly when the delivered result is zero.
- R3: The `op` encoding is 0 = add, 1 = subtract, 2 or 3 = compare. Binary add returns a+b+`carry_in` and C is the carry out of the active width. Binary subtract returns a−b−`carry_in` and C is the borrow.
- R4: In binary arithmetic, V is set when the signed result leaves the range of the active width (−128..127 for 8-bit, −32768..32767 for 16-bit, −8..7 in unpack mode). N equals the top bit of the active width.
- R5: A compare performs a−b with `carry_in` ignored. It sets C when a is unsigned-less than b, drives `result_wr` to 0, and add/subtract drive it to 1.
- R6: A decimal 8-bit add works digit by digit, low digit first. The digit sum t = a+b+carry; when t > 9 the digit becomes (t+6) mod 16 and a carry passes on. C is the final carry.
- R7: A decimal 8-bit subtract works digit by digit. The digit difference t = a−b−borrow; when t < 0 the digit becomes (t−6) mod 16 and a borrow passes on. C is the final borrow.
- R8: In decimal mode with an 8-bit operation, V and N are 0.
- R9: Unpack mode on an 8-bit binary operation uses only bits 3:0 of each operand. It returns `result[15:4]`=0, and the flags come from the 4-bit operation (C from bit 3, N = bit 3).
- R10: With decimal and unpack modes both set on an 8-bit operation, only the low BCD digit is processed. The result is that digit alone, and C is that digit's carry or borrow.
- R11: A 16-bit operation (`wide`=1) ignores the decimal and unpack mode inputs.
- R12: An 8-bit operation without unpack mode returns `result[15:8]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 2 | 0 add, 1 subtract, 2/3 compare |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| dec_mode | input | 1 | Packed BCD arithmetic (8-bit only) |
| unp_mode | input | 1 | Low-nibble arithmetic (8-bit only) |
| carry_in | input | 1 | Carry for add, borrow for subtract |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| out_valid | output | 1 | Result and flags valid |
| result | output | 16 | Arithmetic result |
| result_wr | output | 1 | Result should be written back |
| flags | output | 4 | {N, V, C, Z} |

## Verification
The bench targets the signed boundaries at 0x7F/0x80 and 0x7FFF/0x8000. A design with the overflow taken from the wrong bit, or computed from the 8-bit lane on a 16-bit operation, misses V there.

It also drives decimal digits that sum past 9 or go below zero, including 99+01 and 00−01. A missing or wrong ±6 correction yields hex digits such as 0x9A, or a lost carry.

Unpack vectors put nonzero data in the high nibble and make the low nibble wrap. This catches leaked upper bits, or carry and Z taken at bit 7 rather than bit 3.

Finally, compares are sent with `carry_in` set, and 16-bit operations with both mode inputs set. A design that still writes back on a compare, folds in the carry, or lets the modes reach the wide path is caught.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [1:0] {
      AFU_ADD  = 2'd0,
      AFU_SUB  = 2'd1,
      AFU_CMP  = 2'd2,
      AFU_CMP2 = 2'd3
   } afu_op_e;

   localparam int FLG_Z = 0;
   localparam int FLG_C = 1;
   localparam int FLG_V = 2;
   localparam int FLG_N = 3;
   localparam int FLG_W = 4;

   typedef struct packed {
      logic n;
      logic v;
      logic c;
      logic z;
   } afu_flags_t;

   function automatic logic is_compare(input logic [1:0] code);
      return code[1];
   endfunction

endpackage

// File: rtl/afu_bin_lane.sv
module afu_bin_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   if (W < 2) begin : g_bad_w
      $error("afu_bin_lane: W must be at least 2");
   end

   logic [W-1:0] bx;
   logic [W:0]   ext;
   logic         cx;

   always_comb begin
      bx  = sub ? ~b : b;
      cx  = sub ? ~cin : cin;
      ext = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
   end

   assign sum  = ext[W-1:0];
   assign cout = sub ? ~ext[W] : ext[W];
   assign ovf  = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/afu_bcd_digit.sv
module afu_bcd_digit #(
   parameter int DW = 4
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   input  logic          cin,
   output logic [DW-1:0] d,
   output logic          cout
);
   if (DW != 4) begin : g_bad_dw
      $error("afu_bcd_digit: a decimal digit is 4 bits wide");
   end

   localparam logic [DW:0]   NINE = (DW+1)'(9);
   localparam logic [DW-1:0] SIX  = DW'(6);

   logic [DW:0]   t_add;
   logic [DW+1:0] t_sub;

   always_comb begin
      t_add = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      t_sub = {2'b00, a} - {2'b00, b} - {{(DW+1){1'b0}}, cin};
      if (sub) begin
         if (t_sub[DW+1]) begin
            d    = t_sub[DW-1:0] - SIX;
            cout = 1'b1;
         end else begin
            d    = t_sub[DW-1:0];
            cout = 1'b0;
         end
      end else begin
         if (t_add > NINE) begin
            d    = t_add[DW-1:0] + SIX;
            cout = 1'b1;
         end else begin
            d    = t_add[DW-1:0];
            cout = 1'b0;
         end
      end
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic              wide,
   input  logic              dec_mode,
   input  logic              unp_mode,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              result_wr,
   output logic [FLG_W-1:0]  flags
);
   localparam int DIGIT_W = 4;
   localparam int NDIG    = NARROW_W / DIGIT_W;

   if (DATA_W != 2 * NARROW_W) begin : g_bad_data_w
      $error("alu_flag_unit: DATA_W must be twice NARROW_W");
   end
   if ((NARROW_W % DIGIT_W) != 0) begin : g_bad_narrow_w
      $error("alu_flag_unit: NARROW_W must be a whole number of digits");
   end

   logic sub_op;
   logic cin_eff;

   assign sub_op  = (op != AFU_ADD);
   assign cin_eff = is_compare(op) ? 1'b0 : carry_in;

   // binary lanes: full, narrow, nibble
   logic [DATA_W-1:0]   w_sum;
   logic                w_c, w_v;
   logic [NARROW_W-1:0] b_sum;
   logic                b_c, b_v;
   logic [DIGIT_W-1:0]  n_sum;
   logic                n_c, n_v;

   afu_bin_lane #(.W(DATA_W)) u_lane_wide (
      .a(opa), .b(opb), .sub(sub_op), .cin(cin_eff),
      .sum(w_sum), .cout(w_c), .ovf(w_v)
   );

   afu_bin_lane #(.W(NARROW_W)) u_lane_byte (
      .a(opa[NARROW_W-1:0]), .b(opb[NARROW_W-1:0]), .sub(sub_op), .cin(cin_eff),
      .sum(b_sum), .cout(b_c), .ovf(b_v)
   );

   afu_bin_lane #(.W(DIGIT_W)) u_lane_nib (
      .a(opa[DIGIT_W-1:0]), .b(opb[DIGIT_W-1:0]), .sub(sub_op), .cin(cin_eff),
      .sum(n_sum), .cout(n_c), .ovf(n_v)
   );

   // decimal digit chain, low digit first
   logic [NARROW_W-1:0] bcd_r;
   logic [NDIG:0]       dc;

   assign dc[0] = cin_eff;

   for (genvar g = 0; g < NDIG; g++) begin : g_digit
      afu_bcd_digit #(.DW(DIGIT_W)) u_dig (
         .a   (opa[g*DIGIT_W +: DIGIT_W]),
         .b   (opb[g*DIGIT_W +: DIGIT_W]),
         .sub (sub_op),
         .cin (dc[g]),
         .d   (bcd_r[g*DIGIT_W +: DIGIT_W]),
         .cout(dc[g+1])
      );
   end

   // result and flag selection
   logic [DATA_W-1:0] nx_r;
   afu_flags_t        nx_f;

   always_comb begin
      nx_r = '0;
      nx_f = '0;
      if (wide) begin
         nx_r   = w_sum;
         nx_f.c = w_c;
         nx_f.v = w_v;
         nx_f.n = w_sum[DATA_W-1];
      end else if (dec_mode) begin
         if (unp_mode) begin
            nx_r[DIGIT_W-1:0] = bcd_r[DIGIT_W-1:0];
            nx_f.c            = dc[1];
         end else begin
            nx_r[NARROW_W-1:0] = bcd_r;
            nx_f.c             = dc[NDIG];
         end
      end else if (unp_mode) begin
         nx_r[DIGIT_W-1:0] = n_sum;
         nx_f.c            = n_c;
         nx_f.v            = n_v;
         nx_f.n            = n_sum[DIGIT_W-1];
      end else begin
         nx_r[NARROW_W-1:0] = b_sum;
         nx_f.c             = b_c;
         nx_f.v             = b_v;
         nx_f.n             = b_sum[NARROW_W-1];
      end
      nx_f.z = (nx_r == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         result_wr <= 1'b0;
         flags     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= nx_r;
            result_wr <= ~is_compare(op);
            flags     <= nx_f;
         end
      end
   end

endmodule

// File: rtl/alu_flag_unit_checks.sv
module alu_flag_unit_checks #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        op,
   input logic              wide,
   input logic              dec_mode,
   input logic              unp_mode,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              result_wr,
   input logic [3:0]        flags
);
   assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op[1]) |=> !result_wr);

   assert_arith_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op[1]) |=> result_wr);

   assert_dec_no_vn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide && dec_mode) |=> (flags[2] == 1'b0 && flags[3] == 1'b0));

   assert_unp_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide && unp_mode) |=> (result[DATA_W-1:4] == '0));

   assert_byte_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide) |=> (result[DATA_W-1:DATA_W/2] == '0));

endmodule

bind alu_flag_unit alu_flag_unit_checks #(.DATA_W(DATA_W)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .wide     (wide),
   .dec_mode (dec_mode),
   .unp_mode (unp_mode),
   .out_valid(out_valid),
   .result   (result),
   .result_wr(result_wr),
   .flags    (flags)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        wide = 1'b0;
   logic        dec_mode = 1'b0;
   logic        unp_mode = 1'b0;
   logic        carry_in = 1'b0;
   logic [15:0] opa = '0;
   logic [15:0] opb = '0;
   logic        out_valid;
   logic [15:0] result;
   logic        result_wr;
   logic [3:0]  flags;

   always #5 clk = ~clk;

   alu_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
      .dec_mode(dec_mode), .unp_mode(unp_mode), .carry_in(carry_in),
      .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
      .result_wr(result_wr), .flags(flags)
   );

   typedef struct {
      logic [15:0] r;
      logic        wr;
      logic [3:0]  f;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   int   pushed = 0;
   int   popped = 0;
   bit   done   = 1'b0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [1:0] o, input logic w, input logic d,
                                  input logic u, input logic ci_in,
                                  input logic [15:0] a, input logic [15:0] b);
      exp_t e;
      int ci, bits, mask, half, ua, ub, sa, sb, uu, ss, r, c, v, n;
      bit sub;
      ci  = o[1] ? 0 : int'(ci_in);
      sub = (o != 2'd0);
      r = 0; c = 0; v = 0; n = 0;
      if (!w && d) begin
         int nd;
         nd = u ? 1 : 2;
         c  = ci;
         for (int i = 0; i < nd; i++) begin
            int ad, bd, t, dg;
            ad = (int'(a) >> (4*i)) & 15;
            bd = (int'(b) >> (4*i)) & 15;
            if (!sub) begin
               t = ad + bd + c;
               if (t > 9) begin dg = (t + 6) & 15; c = 1; end
               else begin dg = t; c = 0; end
            end else begin
               t = ad - bd - c;
               if (t < 0) begin dg = (t - 6) & 15; c = 1; end
               else begin dg = t; c = 0; end
            end
            r = r | (dg << (4*i));
         end
      end else begin
         bits = w ? 16 : (u ? 4 : 8);
         mask = (1 << bits) - 1;
         half = 1 << (bits - 1);
         ua = int'(a) & mask;
         ub = int'(b) & mask;
         sa = (ua >= half) ? ua - (1 << bits) : ua;
         sb = (ub >= half) ? ub - (1 << bits) : ub;
         if (!sub) begin
            uu = ua + ub + ci; ss = sa + sb + ci; c = (uu > mask) ? 1 : 0;
         end else begin
            uu = ua - ub - ci; ss = sa - sb - ci; c = (uu < 0) ? 1 : 0;
         end
         v = (ss > half - 1 || ss < -half) ? 1 : 0;
         r = uu & mask;
         n = (r >> (bits - 1)) & 1;
      end
      e.r  = 16'(r);
      e.wr = ~o[1];
      e.f  = {n[0], v[0], c[0], (r == 0)};
      return e;
   endfunction

   task automatic drive(input string tag, input logic [1:0] o, input logic w,
                        input logic d, input logic u, input logic ci,
                        input logic [15:0] a, input logic [15:0] b);
      exp_t e;
      e     = model(o, w, d, u, ci, a, b);
      e.tag = tag;
      q.push_back(e);
      pushed++;
      op = o; wide = w; dec_mode = d; unp_mode = u; carry_in = ci;
      opa = a; opb = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (q.size() == 0) begin
            check("R1", "unexpected out_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            popped++;
            check(e.tag, "result", {16'd0, result}, {16'd0, e.r});
            check(e.tag, "result_wr", {31'd0, result_wr}, {31'd0, e.wr});
            check(e.tag, "flags", {28'd0, flags}, {28'd0, e.f});
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired: actual=hang expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
      check("R1", "reset result", {16'd0, result}, 32'd0);
      check("R1", "reset flags", {28'd0, flags}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 compare equal / less, carry_in ignored
      drive("R5", 2'd2, 0, 0, 0, 1, 16'h000A, 16'h000A);
      drive("R5", 2'd3, 0, 0, 0, 1, 16'h0003, 16'h0005);
      drive("R5", 2'd2, 1, 0, 0, 1, 16'h1234, 16'hF000);
      // R2 R3 zero and carry at the byte boundary
      drive("R2", 2'd0, 0, 0, 0, 0, 16'h00FF, 16'h0001);
      drive("R3", 2'd1, 0, 0, 0, 1, 16'h0010, 16'h0010);
      drive("R3", 2'd0, 0, 0, 0, 1, 16'h0022, 16'h0033);
      // R4 signed boundaries
      drive("R4", 2'd0, 0, 0, 0, 0, 16'h007F, 16'h0001);
      drive("R4", 2'd1, 0, 0, 0, 0, 16'h0080, 16'h0001);
      drive("R4", 2'd0, 1, 0, 0, 0, 16'h7FFF, 16'h0001);
      drive("R4", 2'd1, 1, 0, 0, 0, 16'h8000, 16'h0001);
      drive("R3", 2'd0, 1, 0, 0, 0, 16'hFFFF, 16'h0001);
      // R6 R7 decimal
      drive("R6", 2'd0, 0, 1, 0, 0, 16'h0045, 16'h0038);
      drive("R6", 2'd0, 0, 1, 0, 0, 16'h0099, 16'h0001);
      drive("R7", 2'd1, 0, 1, 0, 0, 16'h0042, 16'h0017);
      drive("R7", 2'd1, 0, 1, 0, 0, 16'h0000, 16'h0001);
      drive("R8", 2'd2, 0, 1, 0, 0, 16'h0050, 16'h0090);
      // R9 unpack
      drive("R9", 2'd0, 0, 0, 1, 0, 16'h00F7, 16'h0009);
      drive("R9", 2'd0, 0, 0, 1, 0, 16'h0037, 16'h0001);
      drive("R9", 2'd1, 0, 0, 1, 0, 16'h00A2, 16'h00C5);
      // R10 single decimal digit
      drive("R10", 2'd0, 0, 1, 1, 0, 16'h0008, 16'h0005);
      drive("R10", 2'd1, 0, 1, 1, 0, 16'h0092, 16'h0057);
      // R11 wide ignores modes
      drive("R11", 2'd0, 1, 1, 1, 0, 16'h1234, 16'h0009);
      drive("R11", 2'd1, 1, 1, 0, 0, 16'h0100, 16'h0001);
      // R12 and random sweeps per mode
      for (int m = 0; m < 5; m++) begin
         for (int k = 0; k < 150; k++) begin
            logic [15:0] ra, rb;
            logic [1:0]  ro;
            string       tg;
            ra = 16'($urandom);
            rb = 16'($urandom);
            ro = 2'($urandom);
            if (m == 1 || m == 3) begin
               ra = {ra[15:8], 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
               rb = {rb[15:8], 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            end
            case (m)
               0: tg = "R12";
               1: tg = (ro == 2'd0) ? "R6" : "R7";
               2: tg = "R9";
               3: tg = "R10";
               default: tg = "R11";
            endcase
            drive(tg, ro, (m == 4), (m == 1 || m == 3 || (m == 4 && k[0])),
                  (m == 2 || m == 3 || (m == 4 && k[1])), 1'($urandom), ra, rb);
         end
      end
      repeat (3) @(negedge clk);
      check("R1", "all results delivered", popped, pushed);
      finish_run();
   end

endmodule